// File: doc/BRIEF.md
# Lockstep Redundancy and Bus Parity Monitor

This block watches a processor bus interface for two kinds of corruption. In checker mode a second, identical unit runs in lockstep with the master, cycle for cycle, and computes the same outputs. The monitor compares the master's outputs with the shadow unit's outputs and raises an error on any difference. Checker mode is selected by an input, so the same block can sit beside a master that has no shadow.

In every mode the monitor checks even parity on the data bus, one parity bit per byte lane, and on the address bus, one parity bit for the whole address. All checks are made only in cycles where the transfer strobe is high. Each error output is registered and pulses for one cycle, one clock after the offending transfer. A sticky status word records each error kind until software-visible logic elsewhere pulses the clear input.

Top module: `lockstep_integrity_monitor`

## Requirements
- R1: While reset is high and in the first cycle after it, every error output, every lane flag and every sticky bit is 0.
- R2: When `checker_mode` and `xfer_valid` are both high and `master_out` differs from `shadow_out` in any bit, `lockstep_err` is high in the next cycle.
- R3: `lockstep_err` stays low in the cycle after any transfer where `checker_mode` or `xfer_valid` is low, or where the two output vectors are equal.
- R4: Byte lane i covers `data_bus[8i+7:8i]` together with `data_par[i]`; the lane is in error when those nine bits hold an odd number of ones. `data_par_lane[i]` is high in the next cycle for each lane in error, and `data_par_err` is high in that cycle when any lane is in error.
- R5: The address check covers all 32 bits of `addr_bus` with `addr_par`; when those 33 bits hold an odd number of ones, `addr_par_err` is high in the next cycle.
- R6: Parity checks are made only when `xfer_valid` is high and do not depend on `checker_mode`; with `xfer_valid` low no parity flag rises in the next cycle.
- R7: `sticky_status` bit 0 records lockstep errors, bit 1 data parity errors and bit 2 address parity errors; each bit becomes 1 in the same cycle as its error pulse and stays 1 until cleared.
- R8: A cycle with `clear_sticky` high clears the sticky word at the next edge, except that an error detected in that same cycle sets its bit.
- R9: Each error pulse lasts one cycle: after a transfer with no fault the corresponding output is low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| checker_mode | input | 1 | Enables the lockstep comparison |
| xfer_valid | input | 1 | Marks a cycle carrying a transfer to check |
| master_out | input | 96 | Outputs driven by the master unit |
| shadow_out | input | 96 | Same outputs computed by the lockstep shadow unit |
| data_bus | input | 64 | Data bus |
| data_par | input | 8 | Even parity, one bit per data byte |
| addr_bus | input | 32 | Address bus |
| addr_par | input | 1 | Even parity over the address |
| clear_sticky | input | 1 | Clears the sticky status word |
| lockstep_err | output | 1 | Registered master/shadow mismatch pulse |
| data_par_err | output | 1 | Registered pulse, any data lane in error |
| data_par_lane | output | 8 | Registered per-lane data parity error flags |
| addr_par_err | output | 1 | Registered address parity error pulse |
| sticky_status | output | 3 | Latched error kinds: lockstep, data, address |

## Verification
A wrong lane index or a broken parity tree shows at the ports one cycle after the faulty transfer, as a lane flag on the wrong byte or a missing pulse, so single-bit flips are driven in every lane and across the address. A stuck or wrongly gated comparator shows as a pulse appearing with checker mode off or vanishing with it on, again one cycle later. A sticky register that loses state or ignores the clear ordering shows in `sticky_status` at the very next edge, which is checked every cycle against a model of set-over-clear.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int ERR_KINDS = 3;

  typedef struct packed {
    logic addr_par;
    logic data_par;
    logic lockstep;
  } err_vec_t;
endpackage

// File: rtl/parity_lane_checker.sv
module parity_lane_checker #(
  parameter int LANE_W = 8,
  parameter int LANES  = 8,
  localparam int BUS_W = LANE_W * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             check_en,
  input  logic [BUS_W-1:0] bus,
  input  logic [LANES-1:0] par,
  output logic [LANES-1:0] lane_hit,
  output logic [LANES-1:0] lane_err_q
);
  logic [LANES-1:0] odd_lane;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign odd_lane[g] = ^{bus[g*LANE_W +: LANE_W], par[g]};
  end

  assign lane_hit = check_en ? odd_lane : '0;

  always_ff @(posedge clk) begin
    if (rst) lane_err_q <= '0;
    else     lane_err_q <= lane_hit;
  end

  // R6: no flag follows a cycle without a transfer
  a_r6_idle_no_flag: assert property (@(posedge clk) disable iff (rst)
    !check_en |=> (lane_err_q == '0));
  // R9: a flag implies the previous cycle was checked
  a_r9_flag_needs_check: assert property (@(posedge clk) disable iff (rst)
    (lane_err_q != '0) |-> $past(check_en));
endmodule

// File: rtl/lockstep_comparator.sv
module lockstep_comparator #(
  parameter int CMP_W = 96
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [CMP_W-1:0] primary,
  input  logic [CMP_W-1:0] redundant,
  output logic             mismatch_hit,
  output logic             mismatch_q
);
  logic [CMP_W-1:0] diff;

  assign diff         = primary ^ redundant;
  assign mismatch_hit = enable && (diff != '0);

  always_ff @(posedge clk) begin
    if (rst) mismatch_q <= 1'b0;
    else     mismatch_q <= mismatch_hit;
  end

  // R2: enabled disagreement raises the error next cycle
  a_r2_mismatch_flags: assert property (@(posedge clk) disable iff (rst)
    (enable && (primary != redundant)) |=> mismatch_q);
  // R3: disabled or agreeing cycles leave the error low
  a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    (!enable || (primary == redundant)) |=> !mismatch_q);
endmodule

// File: rtl/sticky_error_reg.sv
module sticky_error_reg #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic [N-1:0] set,
  output logic [N-1:0] status
);
  always_ff @(posedge clk) begin
    if (rst)        status <= '0;
    else if (clear) status <= set;
    else            status <= status | set;
  end

  // R7: bits never drop without a clear
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !clear |=> ((status & $past(status)) == $past(status)));
  // R8: a set during clear survives
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    (clear && (set != '0)) |=> ((status & $past(set)) == $past(set)));
endmodule

// File: rtl/lockstep_integrity_monitor.sv
module lockstep_integrity_monitor #(
  parameter int CMP_W   = 96,
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 32,
  parameter int BYTE_W  = 8,
  localparam int LANES  = DATA_W / BYTE_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          checker_mode,
  input  logic                          xfer_valid,
  input  logic [CMP_W-1:0]              master_out,
  input  logic [CMP_W-1:0]              shadow_out,
  input  logic [DATA_W-1:0]             data_bus,
  input  logic [LANES-1:0]              data_par,
  input  logic [ADDR_W-1:0]             addr_bus,
  input  logic                          addr_par,
  input  logic                          clear_sticky,
  output logic                          lockstep_err,
  output logic                          data_par_err,
  output logic [LANES-1:0]              data_par_lane,
  output logic                          addr_par_err,
  output logic [lsm_pkg::ERR_KINDS-1:0] sticky_status
);
  import lsm_pkg::*;

  logic             ls_hit;
  logic [LANES-1:0] data_hit;
  logic             addr_hit;
  logic             data_err_q;
  err_vec_t         detect;

  lockstep_comparator #(.CMP_W(CMP_W)) u_cmp (
    .clk(clk), .rst(rst),
    .enable(checker_mode && xfer_valid),
    .primary(master_out), .redundant(shadow_out),
    .mismatch_hit(ls_hit), .mismatch_q(lockstep_err)
  );

  parity_lane_checker #(.LANE_W(BYTE_W), .LANES(LANES)) u_data_par (
    .clk(clk), .rst(rst), .check_en(xfer_valid),
    .bus(data_bus), .par(data_par),
    .lane_hit(data_hit), .lane_err_q(data_par_lane)
  );

  parity_lane_checker #(.LANE_W(ADDR_W), .LANES(1)) u_addr_par (
    .clk(clk), .rst(rst), .check_en(xfer_valid),
    .bus(addr_bus), .par(addr_par),
    .lane_hit(addr_hit), .lane_err_q(addr_par_err)
  );

  always_ff @(posedge clk) begin
    if (rst) data_err_q <= 1'b0;
    else     data_err_q <= |data_hit;
  end
  assign data_par_err = data_err_q;

  assign detect.lockstep = ls_hit;
  assign detect.data_par = |data_hit;
  assign detect.addr_par = addr_hit;

  sticky_error_reg #(.N(ERR_KINDS)) u_sticky (
    .clk(clk), .rst(rst), .clear(clear_sticky),
    .set(detect), .status(sticky_status)
  );

  // R7: every pulse is mirrored in the sticky word
  a_r7_lockstep_sticky: assert property (@(posedge clk) disable iff (rst)
    lockstep_err |-> sticky_status[0]);
  a_r7_data_sticky: assert property (@(posedge clk) disable iff (rst)
    data_par_err |-> sticky_status[1]);
  a_r7_addr_sticky: assert property (@(posedge clk) disable iff (rst)
    addr_par_err |-> sticky_status[2]);
  // R4: summary flag and lane flags agree
  a_r4_lane_summary: assert property (@(posedge clk) disable iff (rst)
    data_par_err == (data_par_lane != '0));
endmodule

// File: tb/lockstep_integrity_monitor_bench.sv
module lockstep_integrity_monitor_bench;
  logic        clk = 0;
  logic        rst;
  logic        checker_mode, xfer_valid, addr_par, clear_sticky;
  logic [95:0] master_out, shadow_out;
  logic [63:0] data_bus;
  logic [7:0]  data_par;
  logic [31:0] addr_bus;
  logic        lockstep_err, data_par_err, addr_par_err;
  logic [7:0]  data_par_lane;
  logic [2:0]  sticky_status;

  int checks = 0, errors = 0;
  logic       e_ls, e_dp, e_ap;
  logic [7:0] e_lane;
  logic [2:0] e_st;

  always #2 clk = ~clk;

  lockstep_integrity_monitor u_lockstep_integrity_monitor (.*);

  function automatic logic [7:0] good_par(input logic [63:0] d);
    logic [7:0] p;
    for (int i = 0; i < 8; i++) p[i] = ^d[i*8 +: 8];
    return p;
  endfunction

  function automatic logic [7:0] bad_lanes(input logic [63:0] d, input logic [7:0] p);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) begin
      int ones = 0;
      for (int k = 0; k < 8; k++) ones += d[i*8+k];
      ones += p[i];
      b[i] = ones[0];
    end
    return b;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycle();
    logic [7:0] lanes;
    lanes = xfer_valid ? bad_lanes(data_bus, data_par) : 8'h0;
    e_ls = checker_mode && xfer_valid && (master_out != shadow_out);
    e_lane = lanes;
    e_dp = lanes != 0;
    e_ap = xfer_valid && (^{addr_bus, addr_par});
    e_st = (clear_sticky ? 3'b0 : e_st) | {e_ap, e_dp, e_ls};
    @(posedge clk); #1;
    chk("R2/R3 lockstep_err", {7'b0, lockstep_err}, {7'b0, e_ls});
    chk("R4 data_par_lane", data_par_lane, e_lane);
    chk("R4 data_par_err", {7'b0, data_par_err}, {7'b0, e_dp});
    chk("R5 addr_par_err", {7'b0, addr_par_err}, {7'b0, e_ap});
    chk("R7/R8 sticky_status", {5'b0, sticky_status}, {5'b0, e_st});
    @(negedge clk);
  endtask

  task automatic idle();
    checker_mode = 0; xfer_valid = 0; clear_sticky = 0;
    master_out = '0; shadow_out = '0; data_bus = '0; data_par = '0;
    addr_bus = '0; addr_par = 0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset outputs", {lockstep_err, data_par_err, addr_par_err, 2'b0, sticky_status}, 8'h0);
    chk("R1 reset lanes", data_par_lane, 8'h0);
    @(negedge clk); rst = 0; e_st = 0;
    cycle(); // R1 first cycle after reset stays clean

    // R4 single-bit flip in each lane, even in checker mode off
    for (int i = 0; i < 8; i++) begin
      xfer_valid = 1; data_bus = 64'h0123_4567_89ab_cdef;
      data_par = good_par(data_bus) ^ (8'h1 << i);
      cycle();
    end
    // R5 address flips, R6 ignored when not valid
    xfer_valid = 1; data_par = good_par(data_bus); addr_bus = 32'h8000_0001; addr_par = 1;
    cycle();
    xfer_valid = 0; data_par = ~data_par; cycle(); // R6
    // R9 pulses end after a clean transfer
    xfer_valid = 1; data_par = good_par(data_bus); addr_par = 0; cycle();
    // R8 clear alone
    clear_sticky = 1; cycle(); clear_sticky = 0;
    // R3 mismatch ignored with checker mode off
    master_out = 96'h1; shadow_out = 96'h0; cycle();
    // R2 mismatch in top bit, checker mode on
    checker_mode = 1; master_out = {1'b1, 95'h0}; cycle();
    // R8 clear with a simultaneous error: set wins
    clear_sticky = 1; cycle();
    master_out = shadow_out; cycle(); clear_sticky = 0;

    // random mix
    for (int n = 0; n < 3000; n++) begin
      checker_mode = $urandom_range(0, 3) != 0;
      xfer_valid   = $urandom_range(0, 4) != 0;
      clear_sticky = $urandom_range(0, 15) == 0;
      master_out   = {$urandom(), $urandom(), $urandom()};
      shadow_out   = master_out;
      if ($urandom_range(0, 7) == 0) shadow_out[$urandom_range(0, 95)] ^= 1'b1;
      data_bus = {$urandom(), $urandom()};
      data_par = good_par(data_bus);
      if ($urandom_range(0, 5) == 0) data_bus[$urandom_range(0, 63)] ^= 1'b1;
      if ($urandom_range(0, 9) == 0) data_par ^= 8'($urandom());
      addr_bus = $urandom();
      addr_par = ^addr_bus;
      if ($urandom_range(0, 6) == 0) addr_bus[$urandom_range(0, 31)] ^= 1'b1;
      cycle();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule